// File: doc/BRIEF.md
# Single-Cycle Request to Wait-Stalled Bus Master Bridge

This bridge lets a processor with a one-cycle memory port drive a memory-mapped master bus whose slaves stall with a wait request. The processor raises a read or write strobe, with its address and write data, for exactly one clock and then moves on. The bridge puts that request on the bus in the same cycle, so no latency is added. It also keeps a private copy of the request. If the slave stalls, the bus is fed from that copy until the stall ends.

Instead of a single done flag, the processor sees a small cycles-left count. The count tells it how many clock edges remain before the read result sits in the bridge's holding register. This lets the processor restart its pipeline one or two cycles ahead of time. Read data appears on the bus a fixed number of cycles after the read is accepted. It is valid there for one cycle only, so the bridge captures it and keeps it until the next read replaces it. Only one transfer may be in flight at any time.

Top module: `cpu_mm_bridge`

## Requirements
- R1: When the bridge is idle and `cpu_rd` or `cpu_wr` is high, the matching bus strobe rises in that same cycle. `mm_addr` and `mm_wdata` then equal `cpu_addr` and `cpu_wdata` combinationally.
- R2: While `mm_wait` is high, the bus strobes, `mm_addr` and `mm_wdata` stay equal to the values of the first cycle, even after the processor inputs change or drop.
- R3: A bus strobe is low in the cycle after the cycle in which it was high with `mm_wait` low, unless a new processor request starts in that cycle. After a read, no strobe may rise in that cycle.
- R4: `cpu_left` reads 3 in every cycle in which a bus strobe is high and `mm_wait` is high.
- R5: `cpu_left` holds the number of clock edges left until the result is usable, saturated at 3. For a read, it is min(RD_LAT+1, 3) in the accept cycle and then falls by one each cycle, reaching 0 in the first cycle in which `cpu_rdata` holds the result. For a write, it is 1 in the accept cycle and 0 afterwards. When idle it is 0.
- R6: `mm_rdata` is sampled exactly RD_LAT cycles after the read's accept cycle. The sampled value is then held on `cpu_rdata` through writes and idle cycles until the next read result replaces it.
- R7: A processor strobe that arrives while a transfer is still pending (`cpu_left` nonzero) is ignored. No bus strobe results from it, either then or later.
- R8: If `cpu_rd` and `cpu_wr` are both high at the start, the read is performed and `mm_wr` stays low.
- R9: While `rst` is high, both bus strobes are low even if a processor strobe is high, and `cpu_left` is 0. After the first clock edge in reset, `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | AW | Processor address, valid in the request cycle only |
| cpu_wdata | input | DW | Processor write data, valid in the request cycle only |
| cpu_rd | input | 1 | One-cycle read request |
| cpu_wr | input | 1 | One-cycle write request |
| cpu_rdata | output | DW | Held read result |
| cpu_left | output | 2 | Clock edges left until the result is usable, saturated at 3 |
| mm_addr | output | AW | Bus address |
| mm_wdata | output | DW | Bus write data |
| mm_rd | output | 1 | Bus read strobe |
| mm_wr | output | 1 | Bus write strobe |
| mm_wait | input | 1 | Slave stall request |
| mm_rdata | input | DW | Bus read data, valid RD_LAT cycles after acceptance |

## Verification
Reads and writes are swept over stall lengths from zero to four cycles, each with a distinct address and data. The zero-stall case separates same-cycle forwarding from the registered copy, and the longer stalls show that the copy stays stable after the processor inputs are scrambled. While each transfer is pending, a conflicting strobe is injected to show that it is dropped. The bus read data is set to the complement of the result outside its single valid cycle, so sampling one cycle early or late is caught. Some reads also carry a simultaneous write strobe to exercise read priority, and the held result is checked again after the writes that follow.

// File: rtl/cpu_mm_bridge.sv
module cpu_mm_bridge #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  output logic [DW-1:0] cpu_rdata,
  output logic [1:0]    cpu_left,
  output logic [AW-1:0] mm_addr,
  output logic [DW-1:0] mm_wdata,
  output logic          mm_rd,
  output logic          mm_wr,
  input  logic          mm_wait,
  input  logic [DW-1:0] mm_rdata
);
  localparam int LW = (RD_LAT < 1) ? 1 : $clog2(RD_LAT + 1);
  localparam logic [LW-1:0] LAT_V = LW'(RD_LAT);
  localparam logic [1:0] ACC_CNT = (RD_LAT + 1 > 3) ? 2'd3 : 2'(RD_LAT + 1);

  logic          pend;
  logic [AW-1:0] q_addr;
  logic [DW-1:0] q_wdata;
  logic          q_rd, q_wr;
  logic [LW-1:0] lat_cnt;
  logic [LW+1:0] lat_ext;

  wire idle     = !pend && (lat_cnt == '0);
  wire start    = !rst && idle && (cpu_rd || cpu_wr);
  wire start_rd = start && cpu_rd;
  wire start_wr = start && !cpu_rd;

  assign mm_addr  = pend ? q_addr  : cpu_addr;
  assign mm_wdata = pend ? q_wdata : cpu_wdata;
  assign mm_rd    = pend ? q_rd    : start_rd;
  assign mm_wr    = pend ? q_wr    : start_wr;

  wire active    = mm_rd || mm_wr;
  wire rd_accept = mm_rd && !mm_wait;
  wire capture   = (lat_cnt == LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      q_rd    <= 1'b0;
      q_wr    <= 1'b0;
      lat_cnt <= '0;
    end else begin
      if (start) begin
        q_addr  <= cpu_addr;
        q_wdata <= cpu_wdata;
        q_rd    <= start_rd;
        q_wr    <= start_wr;
      end
      if (start && mm_wait)
        pend <= 1'b1;
      else if (pend && !mm_wait)
        pend <= 1'b0;
      if (rd_accept)
        lat_cnt <= LAT_V;
      else if (lat_cnt != '0)
        lat_cnt <= lat_cnt - LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cpu_rdata <= '0;
    else if (capture)
      cpu_rdata <= mm_rdata;
  end

  assign lat_ext = {2'b00, lat_cnt};

  always_comb begin
    if (lat_cnt != '0)
      cpu_left = (lat_ext > (LW+2)'(3)) ? 2'd3 : lat_ext[1:0];
    else if (active && mm_wait)
      cpu_left = 2'd3;
    else if (mm_rd)
      cpu_left = ACC_CNT;
    else if (mm_wr)
      cpu_left = 2'd1;
    else
      cpu_left = 2'd0;
  end
endmodule

// File: rtl/cpu_mm_bridge_chk.sv
module cpu_mm_bridge_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] cpu_addr,
  input logic [DW-1:0] cpu_rdata,
  input logic [1:0]    cpu_left,
  input logic [AW-1:0] mm_addr,
  input logic [DW-1:0] mm_wdata,
  input logic          mm_rd,
  input logic          mm_wr,
  input logic          mm_wait
);
  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (rst)
    $rose(mm_rd) |-> mm_addr == cpu_addr); // R1
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
    (mm_rd || mm_wr) && mm_wait |=> $stable(mm_addr) && $stable(mm_wdata) && $stable(mm_rd) && $stable(mm_wr)); // R2
  AST_RD_DROP: assert property (@(posedge clk) disable iff (rst)
    mm_rd && !mm_wait |=> !mm_rd && !mm_wr); // R3
  AST_WAIT_CNT: assert property (@(posedge clk) disable iff (rst)
    (mm_rd || mm_wr) && mm_wait |-> cpu_left == 2'd3); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    cpu_left == 2'd0 |=> $stable(cpu_rdata)); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(mm_rd && mm_wr)); // R8
endmodule

bind cpu_mm_bridge cpu_mm_bridge_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
  .cpu_left(cpu_left), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
  .mm_rd(mm_rd), .mm_wr(mm_wr), .mm_wait(mm_wait)
);

// File: tb/sim_cpu_mm_bridge.sv
module sim_cpu_mm_bridge;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LAT = 2;
  localparam int ACC = (LAT + 1 > 3) ? 3 : LAT + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [DW-1:0] cpu_rdata;
  logic [1:0] cpu_left;
  logic [AW-1:0] mm_addr;
  logic [DW-1:0] mm_wdata;
  logic mm_rd, mm_wr;
  logic mm_wait = 1'b0;
  logic [DW-1:0] mm_rdata = '0;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [DW-1:0] last_rd = '0;

  always #4 clk = ~clk;

  cpu_mm_bridge #(.AW(AW), .DW(DW), .RD_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .cpu_left(cpu_left),
    .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_rd(mm_rd), .mm_wr(mm_wr),
    .mm_wait(mm_wait), .mm_rdata(mm_rdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic rd_txn(input logic [AW-1:0] a, input logic [DW-1:0] d, input int waits, input bit both);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_wr = both; cpu_addr = a; cpu_wdata = ~d;
    mm_wait = (waits > 0); mm_rdata = ~d;
    #2;
    chk("R1 rd strobe", mm_rd, 1);
    chk("R1 rd addr", mm_addr, a);
    chk("R8 no wr", mm_wr, 0);
    chk("R4/R5 first cnt", cpu_left, (waits > 0) ? 3 : ACC);
    for (int i = 1; i <= waits; i++) begin
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b1; cpu_addr = ~a; mm_wait = (i < waits);
      #2;
      chk("R2 rd held", mm_rd, 1);
      chk("R7 wr ignored", mm_wr, 0);
      chk("R2 addr held", mm_addr, a);
      chk("R4 cnt", cpu_left, (i < waits) ? 3 : ACC);
    end
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b1; cpu_addr = ~a; mm_wait = 1'b1;
    #2;
    chk("R3 rd dropped", mm_rd, 0);
    chk("R7 wr ignored", mm_wr, 0);
    chk("R5 cnt", cpu_left, LAT);
    @(negedge clk);
    cpu_wr = 1'b0; mm_wait = 1'b0; mm_rdata = d;
    #2;
    chk("R5 cnt", cpu_left, LAT - 1);
    chk("R7 no late wr", mm_wr, 0);
    @(negedge clk);
    mm_rdata = ~d;
    #2;
    chk("R5 cnt", cpu_left, 0);
    chk("R6 rdata", cpu_rdata, d);
    last_rd = d;
  endtask

  task automatic wr_txn(input logic [AW-1:0] a, input logic [DW-1:0] d, input int waits);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_rd = 1'b0; cpu_addr = a; cpu_wdata = d;
    mm_wait = (waits > 0); mm_rdata = d;
    #2;
    chk("R1 wr strobe", mm_wr, 1);
    chk("R1 wr addr", mm_addr, a);
    chk("R1 wr data", mm_wdata, d);
    chk("R4/R5 first cnt", cpu_left, (waits > 0) ? 3 : 1);
    for (int i = 1; i <= waits; i++) begin
      @(negedge clk);
      cpu_wr = 1'b0; cpu_rd = 1'b1; cpu_addr = ~a; cpu_wdata = ~d; mm_wait = (i < waits);
      #2;
      chk("R2 wr held", mm_wr, 1);
      chk("R7 rd ignored", mm_rd, 0);
      chk("R2 addr held", mm_addr, a);
      chk("R2 data held", mm_wdata, d);
      chk("R4/R5 cnt", cpu_left, (i < waits) ? 3 : 1);
    end
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0; mm_wait = 1'b0;
    #2;
    chk("R3 wr dropped", mm_wr, 0);
    chk("R7 no late rd", mm_rd, 0);
    chk("R5 idle cnt", cpu_left, 0);
    chk("R6 rdata kept", cpu_rdata, last_rd);
  endtask

  initial begin
    cpu_rd = 1'b1;
    @(negedge clk);
    #2;
    chk("R9 rd in reset", mm_rd, 0);
    chk("R9 wr in reset", mm_wr, 0);
    chk("R9 cnt in reset", cpu_left, 0);
    chk("R9 rdata in reset", cpu_rdata, 0);
    @(negedge clk);
    cpu_rd = 1'b0; rst = 1'b0;
    for (int w = 0; w <= 4; w++) begin
      for (int k = 0; k < 3; k++) begin
        rd_txn(AW'(16'h0100 + w * 16 + k * 3), 32'hA500_0000 ^ (w << 8) ^ (k << 20) ^ 32'h5A, w, k == 2);
        wr_txn(AW'(16'h2200 + w * 32 + k * 5), 32'h0F0F_1234 + w * 97 + k * 11, w);
      end
    end
    repeat (3) @(negedge clk);
    chk("R6 hold idle", cpu_rdata, last_rd);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule